// File: doc/BRIEF.md
# Recirculating Serial Shift Register

This block is a fixed-length serial delay line of 64 full stages with a selectable serial source. A source-select input chooses, at every rising clock edge, whether the bit entering the first stage comes from the primary input or from a second input. Wiring the second input back to the register output makes the contents circulate, so the stored word is preserved while it is read out. With the second input driven by an unrelated stream, the same select acts as a plain two-way data selector.

The last stage drives the serial output and its complement. A trailing half stage captures the serial output on the falling clock edge and gives a copy that lags by half a period. Downstream registers with slow clock edges can use it to cascade. A clock-follow output pulses high from each rising edge that shifts until the next falling edge, so a chained register can be stepped from it. A hold input freezes every stage, the half stage and the clock-follow output. A synchronous clear, intended for test, zeroes the whole chain.

Top module: `serial_recirc_shreg`

## Requirements
- R1: After synchronous reset `q` = 0, `q_n` = 1, `q_half` = 0 and `clk_dly` = 0.
- R2: A bit present on the selected input at a rising edge where shifting is enabled reaches `q` after exactly 64 enabled rising edges, counting that edge.
- R3: With `src_sel` = 0 the first stage takes `din_a` and `din_b` has no effect. With `src_sel` = 1 it takes `din_b` and `din_a` has no effect. Both are sampled at the rising edge.
- R4: With `src_sel` = 1 and `din_b` driven from `q`, a 64-bit word loaded earlier comes out of `q` bit by bit in load order, and after 64 shifts `q` again shows the first loaded bit.
- R5: While `hold` = 1, no full stage and not the half stage changes: `q` and `q_half` keep their values across any number of edges.
- R6: `clr` = 1 at a rising edge zeroes all 64 stages, and it wins over `hold`. The half stage reads 0 from the next falling edge.
- R7: `q_half` takes the value of `q` at each falling edge. Between a rising edge and the next falling edge it still shows the value `q` had before that rising edge.
- R8: `clk_dly` is 1 from a rising edge that shifts until the next falling edge, and 0 at all other times, including every cycle with `hold` = 1.
- R9: `q_n` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the chain shifts on the rising edge, the half stage on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous test clear of all stages |
| hold | input | 1 | Freezes shifting while high |
| src_sel | input | 1 | 0 selects `din_a`, 1 selects `din_b` |
| din_a | input | 1 | Primary serial data input |
| din_b | input | 1 | Second serial input, normally wired from `q` |
| q | output | 1 | Last full stage |
| q_n | output | 1 | Complement of the last full stage |
| q_half | output | 1 | Half-stage copy of `q`, updated on the falling edge |
| clk_dly | output | 1 | Clock-follow output for cascading |

## Verification
The hardest state to reach from the ports is a full-length recirculation with a known, non-trivial word. The full chain has to be filled through one input, and then the contents have to come back intact after exactly 64 shifts while the second input is closed over the output. The bench loads several 64-bit patterns, through `din_a` and through `din_b` with the other input driven to the inverse bit. It then circulates or drains them while it predicts each output bit from the pattern index modulo 64. Hold windows and a clear asserted together with hold are placed in the middle of those runs, where the contents are non-zero, so a missed freeze or a lost clear changes the predicted stream.

// File: rtl/srr_pkg.sv
package srr_pkg;

  typedef enum logic {
    SRC_PRIMARY = 1'b0,
    SRC_SECOND  = 1'b1
  } src_sel_e;

  localparam int unsigned DEFAULT_DEPTH = 64;

endpackage

// File: rtl/srr_src_mux.sv
module srr_src_mux
  import srr_pkg::*;
(
  input  src_sel_e sel_i,
  input  logic     prim_i,
  input  logic     sec_i,
  output logic     bit_o
);

  always_comb begin
    unique case (sel_i)
      SRC_SECOND: bit_o = sec_i;
      default:    bit_o = prim_i;
    endcase
  end

endmodule

// File: rtl/srr_chain.sv
module srr_chain #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hold,
  input  logic bit_i,
  output logic head_o,
  output logic tail_o,
  output logic tail_n_o
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [LAST:0] stg;
  logic          tail_n;
  logic          adv;

  assign adv = !hold && !clr;

  // first stage takes the selected serial input
  always_ff @(posedge clk) begin
    if (rst || clr)  stg[0] <= 1'b0;
    else if (!hold)  stg[0] <= bit_i;
  end

  // remaining stages, one flop each
  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || clr)  stg[i] <= 1'b0;
      else if (!hold)  stg[i] <= stg[i-1];
    end
  end

  // separate complement flop beside the last stage
  always_ff @(posedge clk) begin
    if (rst || clr)  tail_n <= 1'b1;
    else if (!hold)  tail_n <= ~stg[LAST-1];
  end

  assign head_o   = stg[0];
  assign tail_o   = stg[LAST];
  assign tail_n_o = tail_n;

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> stg[LAST:1] == $past(stg[LAST-1:0]));

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr) |=> $stable(stg));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (stg == '0));

endmodule

// File: rtl/srr_half_stage.sv
module srr_half_stage (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic d_i,
  output logic q_o
);

  always_ff @(negedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (!hold) q_o <= d_i;
  end

  p_half_follow_r7: assert property (@(negedge clk) disable iff (rst)
    !hold |=> q_o == $past(d_i));

  p_half_hold_r5: assert property (@(negedge clk) disable iff (rst)
    hold |=> $stable(q_o));

endmodule

// File: rtl/srr_clk_follow.sv
module srr_clk_follow (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic clk_dly_o
);

  logic rise_tgl;
  logic fall_tgl;

  // toggles on every rising edge that shifts
  always_ff @(posedge clk) begin
    if (rst)        rise_tgl <= 1'b0;
    else if (!hold) rise_tgl <= ~rise_tgl;
  end

  // catches up on the falling edge, closing the pulse
  always_ff @(negedge clk) begin
    if (rst) fall_tgl <= 1'b0;
    else     fall_tgl <= rise_tgl;
  end

  assign clk_dly_o = rise_tgl ^ fall_tgl;

  p_rest_low_r8: assert property (@(posedge clk) disable iff (rst)
    !clk_dly_o);

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> !clk_dly_o);

endmodule

// File: rtl/serial_recirc_shreg.sv
module serial_recirc_shreg
  import srr_pkg::*;
#(
  parameter int unsigned DEPTH = DEFAULT_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hold,
  input  logic src_sel,
  input  logic din_a,
  input  logic din_b,
  output logic q,
  output logic q_n,
  output logic q_half,
  output logic clk_dly
);

  src_sel_e sel;
  logic     ser_bit;
  logic     head;

  assign sel = src_sel_e'(src_sel);

  srr_src_mux u_mux (
    .sel_i  (sel),
    .prim_i (din_a),
    .sec_i  (din_b),
    .bit_o  (ser_bit)
  );

  srr_chain #(.DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .hold     (hold),
    .bit_i    (ser_bit),
    .head_o   (head),
    .tail_o   (q),
    .tail_n_o (q_n)
  );

  srr_half_stage u_half (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .d_i  (q),
    .q_o  (q_half)
  );

  srr_clk_follow u_cfol (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .clk_dly_o (clk_dly)
  );

  p_src_a_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr && !src_sel) |=> head == $past(din_a));

  p_src_b_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr && src_sel) |=> head == $past(din_b));

  p_compl_r9: assert property (@(posedge clk) disable iff (rst)
    q_n == !q);

endmodule

// File: tb/test_serial_recirc_shreg.sv
module test_serial_recirc_shreg;

  logic clk = 1'b0;
  logic rst, clr, hold, src_sel, din_a, din_b;
  logic q, q_n, q_half, clk_dly;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_recirc_shreg i_serial_recirc_shreg (
    .clk(clk), .rst(rst), .clr(clr), .hold(hold), .src_sel(src_sel),
    .din_a(din_a), .din_b(din_b), .q(q), .q_n(q_n), .q_half(q_half),
    .clk_dly(clk_dly)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // returns at rising edge + 5
  task automatic tick();
    @(posedge clk); #5;
  endtask

  // go to falling edge + 5, check half stage and clock-follow there
  task automatic fall_check(input logic exp_half);
    @(negedge clk); #5;
    chk(q_half, exp_half, "R7 q_half after fall");
    chk(clk_dly, 1'b0, "R8 clk_dly low after fall");
    chk(q_n, ~q, "R9 complement");
  endtask

  task automatic load(input logic [63:0] p, input bit via_b);
    for (int i = 0; i < 64; i++) begin
      src_sel = via_b;
      din_a   = via_b ? ~p[i] : p[i];
      din_b   = via_b ? p[i] : ~p[i];
      tick();
    end
  endtask

  // circulate 64 times, predicting q from the pattern index
  task automatic circulate(input logic [63:0] p);
    for (int n = 0; n < 64; n++) begin
      chk(q, p[n], "R4 recirculated bit");
      chk(clk_dly, 1'b1, "R8 clk_dly high after shifting rise");
      if (n > 0) chk(q_half, p[n-1], "R7 q_half lags q");
      src_sel = 1'b1;
      din_b   = q;
      din_a   = ~q;
      fall_check(p[n]);
      tick();
    end
    chk(q, p[0], "R4 first bit returns after 64 shifts");
  endtask

  initial begin
    logic [63:0] pats [3];
    logic [63:0] p;
    logic held_q, held_h;
    pats[0] = 64'hAAAA_5555_F0F0_0F0F;
    pats[1] = 64'hDEAD_BEEF_0123_4567;
    pats[2] = 64'h8000_0000_0000_0001;

    rst = 1; clr = 0; hold = 0; src_sel = 0; din_a = 0; din_b = 0;
    repeat (3) tick();
    rst = 0;
    chk(q, 1'b0, "R1 q reset");
    chk(q_n, 1'b1, "R1 q_n reset");
    chk(q_half, 1'b0, "R1 q_half reset");
    chk(clk_dly, 1'b0, "R1 clk_dly reset");

    // R2: a single one appears after exactly 64 edges
    din_a = 1; tick(); din_a = 0;
    for (int k = 2; k <= 64; k++) begin
      chk(q, 1'b0, "R2 not yet at output");
      tick();
    end
    chk(q, 1'b1, "R2 bit arrives after 64 edges");
    tick();
    chk(q, 1'b0, "R2 bit leaves after one cycle");
    chk(q_half, 1'b1, "R7 q_half still shows previous q");

    // R2/R3/R4: load via primary input, then circulate
    for (int t = 0; t < 3; t++) begin
      p = pats[t];
      load(p, 1'b0);
      circulate(p);
    end

    // R3: load via second input, drain via primary with zeros
    p = pats[1];
    load(p, 1'b1);
    for (int n = 0; n < 64; n++) begin
      chk(q, p[n], "R3 second-source bit drained");
      src_sel = 0; din_a = 0; din_b = 1;
      if (n == 20) begin
        // R5: freeze mid-stream
        hold = 1;
        held_q = q;
        held_h = q_half;
        for (int h = 0; h < 8; h++) begin
          din_a = h[0]; din_b = ~h[0];
          tick();
          chk(q, held_q, "R5 q frozen");
          chk(q_half, held_h, "R5 q_half frozen");
          chk(clk_dly, 1'b0, "R8 clk_dly low in hold");
        end
        hold = 0; din_a = 0; din_b = 1;
      end
      tick();
    end
    chk(q, 1'b0, "R3 din_b ignored while src_sel=0");

    // R6: clear together with hold on loaded contents
    p = pats[0];
    load(p, 1'b0);
    chk(q, p[0], "R6 precondition loaded");
    clr = 1; hold = 1;
    tick();
    clr = 0; hold = 0;
    chk(q, 1'b0, "R6 clear wins over hold");
    chk(q_n, 1'b1, "R9 complement after clear");
    for (int n = 0; n < 64; n++) begin
      src_sel = 1; din_b = q; din_a = 1;
      tick();
      chk(q, 1'b0, "R6 all stages cleared");
      @(negedge clk); #5;
      chk(q_half, 1'b0, "R6 half stage cleared");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule